// File: doc/BRIEF.md
# GPIO Port Controller with Read-Latched Change Interrupts

This block controls an eight-pin general-purpose I/O port. Software programs it through a small synchronous register bus. For each pin it sets an interrupt-enable bit, an interrupt-mode bit and an output-bypass bit, and it writes the port's output data register. Pin inputs pass through a multi-flop synchronizer. A read of the port address returns the synchronized levels and, in the same clock edge, stores them in a per-pin read latch.

Each pin can request an interrupt in one of two ways. In level-low mode it requests while its level is low. In change mode it requests while its level differs from the value held in the read latch. Because that reference only moves when software reads the port, a change-mode pin behaves as active-high after a 0 was read and as active-low after a 1 was read. The request stays up until software reads the port again. The per-pin requests are OR-ed into one interrupt line, which a global enable input gates.

Each output pin is driven either by the data register or by an alternate internal signal. The alternate signal is selected when an internal function forces the pin over or when the pin's bypass bit is set.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the data, interrupt-enable, interrupt-mode and bypass registers and the read latch are all 0, so with hw_alt_sel_i=0 the pad outputs are 0 and irq_o is 0.
- R2: Register map (bus_addr_i): 0 = port, 1 = interrupt enable, 2 = interrupt mode, 3 = bypass. A write at address 0 loads the data register. A read at address 0 returns the synchronized pin levels, and reads at 1 to 3 return the stored registers. Addresses 4 to 7 read as 0 and ignore writes. bus_rdata_o is registered: it shows the result on the clock edge that samples bus_rd_i and holds until the next read.
- R3: A pin whose enable bit is 0 never contributes to irq_o, whatever its mode bit and level.
- R4: A pin with enable=1 and mode=0 requests an interrupt exactly while its synchronized level is 0.
- R5: A pin with enable=1 and mode=1 requests an interrupt while its synchronized level differs from its read-latch bit. It acts as active-high after a 0 was latched and as active-low after a 1 was latched.
- R6: The read latch captures all synchronized pin levels together on each read at address 0, and only then. Reads at other addresses leave it unchanged, so a change request persists until the port is read again.
- R7: A pin whose alternate select is 0 drives pad_o from the data register.
- R8: A pin's alternate select is the OR of hw_alt_sel_i and its bypass bit. When it is 1, pad_o drives alt_data_i for that pin.
- R9: irq_o is 1 exactly when gie_i is 1 and at least one pin requests.
- R10: A pin level change reaches the read data, the read latch and the interrupt evaluation exactly SYNC_STAGES clock edges after it is applied, with a default of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | PIN_W | Write data |
| bus_rdata_o | output | PIN_W | Registered read data |
| pin_i | input | PIN_W | Asynchronous pin levels |
| alt_data_i | input | PIN_W | Alternate internal output data |
| hw_alt_sel_i | input | PIN_W | Hardware-forced alternate select per pin |
| gie_i | input | 1 | Global interrupt enable |
| pad_o | output | PIN_W | Pin output data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters, PIN_W=8 and SYNC_STAGES=2. With these values every enable, mode and latch combination is reachable across the eight pins at once, and the two-edge synchronizer latency can be counted exactly. Random register writes, port reads and pin changes are mixed with directed sequences. Those sequences walk a change-mode pin through both latch polarities, show that its request persists across reads of other addresses, and step a pin edge through the synchronizer one clock at a time.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_PORT     = 3'd0;
  localparam logic [REG_AW-1:0] RA_IRQ_EN   = 3'd1;
  localparam logic [REG_AW-1:0] RA_IRQ_MODE = 3'd2;
  localparam logic [REG_AW-1:0] RA_BYPASS   = 3'd3;

  typedef enum logic [1:0] {
    PIN_IRQ_OFF    = 2'd0,
    PIN_IRQ_LOW    = 2'd1,
    PIN_IRQ_CHANGE = 2'd2
  } pin_irq_kind_e;

  // Per-pin interrupt behaviour from the enable and mode bits.
  function automatic pin_irq_kind_e irq_kind(input logic en, input logic mode);
    if (!en)      return PIN_IRQ_OFF;
    else if (mode) return PIN_IRQ_CHANGE;
    else          return PIN_IRQ_LOW;
  endfunction

  // Request for one pin given its behaviour, level and read-latch reference.
  function automatic logic pin_request(input pin_irq_kind_e kind, input logic lvl,
                                       input logic ref_lvl);
    case (kind)
      PIN_IRQ_LOW:    return ~lvl;
      PIN_IRQ_CHANGE: return lvl ^ ref_lvl;
      default:        return 1'b0;
    endcase
  endfunction

  // Output data for one pin.
  function automatic logic out_pick(input logic sel, input logic alt, input logic dr);
    return sel ? alt : dr;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PIN_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] async_i,
  output logic [PIN_W-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  logic [PIN_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PIN_W-1:0]  wdata_i,
  input  logic [PIN_W-1:0]  pin_sync_i,
  output logic [PIN_W-1:0]  rdata_o,
  output logic [PIN_W-1:0]  data_q_o,
  output logic [PIN_W-1:0]  ie_q_o,
  output logic [PIN_W-1:0]  mode_q_o,
  output logic [PIN_W-1:0]  byp_q_o,
  output logic [PIN_W-1:0]  latch_q_o,
  output logic              port_read_o
);

  logic [PIN_W-1:0] data_q, ie_q, mode_q, byp_q, latch_q, rdata_q;
  logic [PIN_W-1:0] rd_mux;
  logic             wr_data, wr_ie, wr_mode, wr_byp;

  assign wr_data     = wr_i && (addr_i == RA_PORT);
  assign wr_ie       = wr_i && (addr_i == RA_IRQ_EN);
  assign wr_mode     = wr_i && (addr_i == RA_IRQ_MODE);
  assign wr_byp      = wr_i && (addr_i == RA_BYPASS);
  assign port_read_o = rd_i && (addr_i == RA_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ie_q   <= '0;
      mode_q <= '0;
      byp_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata_i;
      if (wr_ie)   ie_q   <= wdata_i;
      if (wr_mode) mode_q <= wdata_i;
      if (wr_byp)  byp_q  <= wdata_i;
    end
  end

  // Reference for change detection: moves only on a port read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latch_q <= '0;
    else if (port_read_o) latch_q <= pin_sync_i;
  end

  always_comb begin
    case (addr_i)
      RA_PORT:     rd_mux = pin_sync_i;
      RA_IRQ_EN:   rd_mux = ie_q;
      RA_IRQ_MODE: rd_mux = mode_q;
      RA_BYPASS:   rd_mux = byp_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign data_q_o  = data_q;
  assign ie_q_o    = ie_q;
  assign mode_q_o  = mode_q;
  assign byp_q_o   = byp_q;
  assign latch_q_o = latch_q;

endmodule

// File: rtl/gpio_irq_eval.sv
module gpio_irq_eval
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic [PIN_W-1:0] ie_i,
  input  logic [PIN_W-1:0] mode_i,
  input  logic [PIN_W-1:0] lvl_i,
  input  logic [PIN_W-1:0] latch_i,
  input  logic             gie_i,
  output logic [PIN_W-1:0] req_o,
  output logic             irq_o
);

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    pin_irq_kind_e kind;
    assign kind     = irq_kind(ie_i[p], mode_i[p]);
    assign req_o[p] = pin_request(kind, lvl_i[p], latch_i[p]);
  end

  assign irq_o = gie_i & (|req_o);

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic [PIN_W-1:0] data_i,
  input  logic [PIN_W-1:0] alt_i,
  input  logic [PIN_W-1:0] hw_sel_i,
  input  logic [PIN_W-1:0] byp_i,
  output logic [PIN_W-1:0] sel_o,
  output logic [PIN_W-1:0] pad_o
);

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    assign sel_o[p] = hw_sel_i[p] | byp_i[p];
    assign pad_o[p] = out_pick(sel_o[p], alt_i[p], data_i[p]);
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [PIN_W-1:0]  bus_wdata_i,
  output logic [PIN_W-1:0]  bus_rdata_o,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [PIN_W-1:0]  alt_data_i,
  input  logic [PIN_W-1:0]  hw_alt_sel_i,
  input  logic              gie_i,
  output logic [PIN_W-1:0]  pad_o,
  output logic              irq_o
);

  // Internal events and state, named for the checker.
  logic [PIN_W-1:0] pin_sync;
  logic [PIN_W-1:0] data_q, ie_q, mode_q, byp_q, latch_q;
  logic [PIN_W-1:0] req_vec, alt_sel;
  logic             port_read;

  gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .wr_i        (bus_wr_i),
    .rd_i        (bus_rd_i),
    .wdata_i     (bus_wdata_i),
    .pin_sync_i  (pin_sync),
    .rdata_o     (bus_rdata_o),
    .data_q_o    (data_q),
    .ie_q_o      (ie_q),
    .mode_q_o    (mode_q),
    .byp_q_o     (byp_q),
    .latch_q_o   (latch_q),
    .port_read_o (port_read)
  );

  gpio_irq_eval #(.PIN_W(PIN_W)) u_irq (
    .ie_i    (ie_q),
    .mode_i  (mode_q),
    .lvl_i   (pin_sync),
    .latch_i (latch_q),
    .gie_i   (gie_i),
    .req_o   (req_vec),
    .irq_o   (irq_o)
  );

  gpio_out_mux #(.PIN_W(PIN_W)) u_out (
    .data_i   (data_q),
    .alt_i    (alt_data_i),
    .hw_sel_i (hw_alt_sel_i),
    .byp_i    (byp_q),
    .sel_o    (alt_sel),
    .pad_o    (pad_o)
  );

endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_rd_i,
  input logic [PIN_W-1:0] bus_rdata_o,
  input logic [PIN_W-1:0] pin_i,
  input logic [PIN_W-1:0] alt_data_i,
  input logic             gie_i,
  input logic [PIN_W-1:0] pad_o,
  input logic             irq_o,
  input logic [PIN_W-1:0] pin_sync,
  input logic [PIN_W-1:0] ie_q,
  input logic [PIN_W-1:0] mode_q,
  input logic [PIN_W-1:0] latch_q,
  input logic [PIN_W-1:0] req_vec,
  input logic [PIN_W-1:0] alt_sel,
  input logic             port_read
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (cyc_q != 3) cyc_q <= cyc_q + 2'd1;
  end

  // R3: disabled pins never raise a request
  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vec & ~ie_q) == '0);

  // R4: a low level-mode pin raises the line when globally enabled
  a_r4_level_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && |(ie_q & ~mode_q & ~pin_sync)) |-> irq_o);

  // R5: a change-mode pin that differs from its latch raises the line
  a_r5_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && |(ie_q & mode_q & (pin_sync ^ latch_q))) |-> irq_o);

  // R6: latch captures on a port read
  a_r6_latch_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_read |=> latch_q == $past(pin_sync));

  // R6: latch holds otherwise
  a_r6_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_read && cyc_q != 0) |=> $stable(latch_q));

  // R8: fully selected port drives alternate data
  a_r8_alt_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alt_sel) |-> pad_o == alt_data_i);

  // R9: global enable gates the line
  a_r9_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  // R9: no request, no line
  a_r9_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vec == '0) |-> !irq_o);

  // R2: read data holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i && cyc_q != 0) |=> $stable(bus_rdata_o));

  // R10: two-edge synchronizer latency
  if (SYNC_STAGES == 2) begin : g_lat
    a_r10_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 2) |-> pin_sync == $past(pin_i, 2));
  end

endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_i       (pin_i),
  .alt_data_i  (alt_data_i),
  .gie_i       (gie_i),
  .pad_o       (pad_o),
  .irq_o       (irq_o),
  .pin_sync    (pin_sync),
  .ie_q        (ie_q),
  .mode_q      (mode_q),
  .latch_q     (latch_q),
  .req_vec     (req_vec),
  .alt_sel     (alt_sel),
  .port_read   (port_read)
);

// File: tb/sim_gpio_port_ctl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctl;

  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   bus_addr_i = '0;
  logic         bus_wr_i = 1'b0;
  logic         bus_rd_i = 1'b0;
  logic [W-1:0] bus_wdata_i = '0;
  logic [W-1:0] bus_rdata_o;
  logic [W-1:0] pin_i = '0;
  logic [W-1:0] alt_data_i = '0;
  logic [W-1:0] hw_alt_sel_i = '0;
  logic         gie_i = 1'b0;
  logic [W-1:0] pad_o;
  logic         irq_o;

  always #2 clk_i = ~clk_i;

  gpio_port_ctl #(.PIN_W(W), .SYNC_STAGES(2)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench model state
  logic [W-1:0] m_dr = '0, m_ie = '0, m_md = '0, m_bp = '0, m_lat = '0;

  function automatic logic model_irq(logic [W-1:0] ie, logic [W-1:0] md, logic [W-1:0] pins,
                                     logic [W-1:0] lat, logic g);
    logic any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (ie[i] == 1'b1) begin
        if (md[i] == 1'b0 && pins[i] == 1'b0) any = 1'b1;
        if (md[i] == 1'b1 && pins[i] != lat[i]) any = 1'b1;
      end
    end
    return any && g;
  endfunction

  function automatic logic [W-1:0] model_pad(logic [W-1:0] dr, logic [W-1:0] bp,
                                             logic [W-1:0] hw, logic [W-1:0] alt);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (bp[i] || hw[i]) ? alt[i] : dr[i];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    case (a)
      3'd0: m_dr = d;
      3'd1: m_ie = d;
      3'd2: m_md = d;
      3'd3: m_bp = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
    if (a == 3'd0) m_lat = pin_i;
  endtask

  task automatic set_pins(logic [W-1:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_outputs(string req);
    check(req, {7'd0, irq_o}, {7'd0, model_irq(m_ie, m_md, pin_i, m_lat, gie_i)});
    check(req, pad_o, model_pad(m_dr, m_bp, hw_alt_sel_i, alt_data_i));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    void'($urandom(32'h5eed_1234));
    gie_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1: reset state
    check("R1 pad", pad_o, '0);
    check("R1 irq", {7'd0, irq_o}, '0);
    bus_read(3'd1, rd); check("R1 ie", rd, '0);
    bus_read(3'd2, rd); check("R1 mode", rd, '0);
    bus_read(3'd3, rd); check("R1 bypass", rd, '0);
    // latch starts 0: change mode with pins 0 gives no request
    bus_write(3'd2, 8'hFF); bus_write(3'd1, 8'hFF);
    check("R1 latch", {7'd0, irq_o}, '0);
    bus_write(3'd1, 8'h00);

    // R2: register map and read data
    bus_write(3'd1, 8'hA5); bus_read(3'd1, rd); check("R2 ie", rd, 8'hA5);
    bus_write(3'd2, 8'h3C); bus_read(3'd2, rd); check("R2 mode", rd, 8'h3C);
    bus_write(3'd3, 8'h81); bus_read(3'd3, rd); check("R2 bypass", rd, 8'h81);
    bus_write(3'd5, 8'hFF); bus_read(3'd5, rd); check("R2 unmapped", rd, 8'h00);
    bus_read(3'd1, rd); check("R2 unmapped write ignored", rd, 8'hA5);
    set_pins(8'h96); bus_read(3'd0, rd); check("R2 port read", rd, 8'h96);
    @(negedge clk_i); check("R2 hold", bus_rdata_o, 8'h96);
    bus_write(3'd1, 8'h00); bus_write(3'd2, 8'h00); bus_write(3'd3, 8'h00);

    // R3: disabled pins, low levels, both modes
    set_pins(8'h00); bus_write(3'd2, 8'h0F);
    check("R3 disabled", {7'd0, irq_o}, '0);
    check_outputs("R3");

    // R4: level-low mode on pin 0
    bus_write(3'd2, 8'h00); set_pins(8'hFF); bus_write(3'd1, 8'h01);
    check("R4 high no req", {7'd0, irq_o}, '0);
    set_pins(8'hFE); check("R4 low req", {7'd0, irq_o}, 8'h01);

    // R5/R6: change mode on pin 0
    bus_write(3'd1, 8'h00); bus_write(3'd2, 8'h01); set_pins(8'h00);
    bus_read(3'd0, rd); bus_write(3'd1, 8'h01);
    check("R5 equal no req", {7'd0, irq_o}, '0);
    set_pins(8'h01); check("R5 active-high", {7'd0, irq_o}, 8'h01);
    repeat (10) @(negedge clk_i);
    check("R6 persists", {7'd0, irq_o}, 8'h01);
    bus_read(3'd2, rd); check("R6 other read keeps latch", {7'd0, irq_o}, 8'h01);
    bus_read(3'd0, rd); check("R6 port read clears", {7'd0, irq_o}, '0);
    set_pins(8'h00); check("R5 active-low", {7'd0, irq_o}, 8'h01);

    // R9: global gate
    gie_i = 1'b0; @(negedge clk_i); check("R9 gie off", {7'd0, irq_o}, '0);
    gie_i = 1'b1; @(negedge clk_i); check("R9 gie on", {7'd0, irq_o}, 8'h01);

    // R7/R8: output selection
    bus_write(3'd0, 8'h5A); alt_data_i = 8'hC3; hw_alt_sel_i = 8'h00;
    @(negedge clk_i); check("R7 data reg", pad_o, 8'h5A);
    bus_write(3'd3, 8'h0F); check("R8 bypass", pad_o, 8'h53);
    hw_alt_sel_i = 8'hF0; @(negedge clk_i); check("R8 hw+bypass", pad_o, 8'hC3);
    bus_write(3'd3, 8'h00); check("R8 hw only", pad_o, 8'hCA);
    hw_alt_sel_i = 8'h00;

    // R10: latency of exactly two edges, level-low on all pins
    set_pins(8'hFF); bus_write(3'd2, 8'h00); bus_write(3'd1, 8'hFF);
    @(negedge clk_i); pin_i = 8'hF7;
    @(negedge clk_i); check("R10 one edge", {7'd0, irq_o}, '0);
    @(negedge clk_i); check("R10 two edges", {7'd0, irq_o}, 8'h01);

    // Random mix (R2..R9)
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: bus_write(3'($urandom_range(0, 7)), 8'($urandom));
        1: begin
          logic [W-1:0] exp_pins;
          exp_pins = pin_i;
          bus_read(3'd0, rd);
          check("R2 random port read", rd, exp_pins);
        end
        2: set_pins(8'($urandom));
        3: begin alt_data_i = 8'($urandom); hw_alt_sel_i = 8'($urandom); @(negedge clk_i); end
        4: begin gie_i = 1'($urandom); @(negedge clk_i); end
        default: begin
          logic [2:0] a;
          logic [W-1:0] e;
          a = 3'($urandom_range(1, 7));
          e = (a == 3'd1) ? m_ie : (a == 3'd2) ? m_md : (a == 3'd3) ? m_bp : '0;
          bus_read(a, rd);
          check("R2 random reg read", rd, e);
        end
      endcase
      check_outputs("R5 R8 R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule